// File: doc/BRIEF.md
# Frame-Transfer CCD Capture Sequencer

This block orders the gate activity needed to take one picture with a frame-transfer image sensor. A rising edge on the host's start request opens a capture. The block first erases the sensor with a timed pulse on the overflow-drain control. It then waits for an exposure window whose length the host sets. Next it shifts every image row into the shielded storage area in fast paired gate phases. Finally it moves rows one at a time into the serial register and clocks each row out pixel by pixel.

While a row is read out, the block starts the downstream digitization engine with a one-cycle pulse. For each pixel it reports the column index and a class: discard, black reference or active. After the last row it drops its busy flag and gives the host-transfer logic a one-cycle go pulse. All timing is counted in cycles of one system clock. Every count is a parameter: the erase width, the row count, the pixels per row and the sizes of the dummy and black-reference regions.

Top module: `ccd_capture_seq`

## Requirements
- R1: A low-to-high change on `start_req`, seen while the block is idle, starts a capture on the next clock edge. From that edge on, `busy` is high, and the phases run in this order: erase, exposure, image shift, then one row step and one row readout per row, then the host hand-off.
- R2: The erase phase holds `drain_reset` high for exactly RESET_CYC consecutive cycles, with every other gate low. `drain_reset` is low at all other times.
- R3: The exposure phase lasts `integ_cycles` cycles, where `integ_cycles` is the value present on the start edge; a value of 0 counts as 1. All gates are low during exposure.
- R4: The image shift lasts 2*ROWS cycles. `image_gate` and `store_gate` are both high in the first cycle of each pair and both low in the second.
- R5: Before each row readout there is a two-cycle row step: `store_gate` alone high for one cycle, then `serial_gate` alone high for one cycle.
- R6: A row readout lasts 2*COLS cycles, two per pixel. In the first cycle of a pixel `serial_gate` is high. In the second cycle `pix_valid` is high and `pix_col` gives the pixel index, counting from 0. `row_go` is high only in the first cycle of the row.
- R7: While `pix_valid` is high, `pix_class` is 1 (discard) for columns below DUMMY_PIX, 2 (black reference) for the next BLACK_PIX columns, and 3 (active) for the remaining columns. When `pix_valid` is low, `pix_class` and `pix_col` are 0.
- R8: After the readout of row ROWS-1 ends, the block holds `busy` low and `host_go` high for exactly one cycle, then returns to idle with every output at 0.
- R9: While a capture runs, new start edges and changes on `integ_cycles` have no effect on any output.
- R10: While `rst_n` is low at a clock edge, the block goes idle and every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | Host capture request; its rising edge starts a capture |
| integ_cycles | input | IW | Exposure length in clock cycles, taken at the start edge |
| drain_reset | output | 1 | Overflow-drain erase pulse |
| image_gate | output | 1 | Image-area transfer gate |
| store_gate | output | 1 | Storage-area transfer gate |
| serial_gate | output | 1 | Serial register gate (row load and pixel clock) |
| row_go | output | 1 | One-cycle start of the pixel engine for each row |
| pix_valid | output | 1 | Pixel slot marker |
| pix_class | output | 2 | Pixel class: 0 none, 1 discard, 2 black reference, 3 active |
| pix_col | output | $clog2(COLS) | Column index of the current pixel |
| busy | output | 1 | Capture in progress |
| host_go | output | 1 | One-cycle start of the host transfer |

## Verification
The bench builds the block with ROWS=3, COLS=8, DUMMY_PIX=2, BLACK_PIX=2, RESET_CYC=4 and IW=4. Each capture therefore takes under ninety cycles, and all three pixel classes appear in every row. The last-row exit and the boundary between row step and readout can be seen several times in one run. With IW=4, the zero-exposure case, a middle value and the largest value 15 are all cheap to run. A start edge and a new exposure value are also given halfway through a capture, to show they have no effect.

// File: rtl/ccd_seq_pkg.sv
// Shared types for the capture sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_EXPOSE,
        ST_SHIFT,
        ST_STEP,
        ST_READ,
        ST_HAND
    } seq_state_t;

    typedef enum logic [1:0] {
        PIX_NONE   = 2'd0,
        PIX_DUMMY  = 2'd1,
        PIX_BLACK  = 2'd2,
        PIX_ACTIVE = 2'd3
    } pix_class_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ccd_step_counter.sv
// Plain up-counter with a synchronous clear. Clear wins over increment.
// Assumes: the owner clears it before it can wrap.
module ccd_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end

endmodule

// File: rtl/ccd_col_classifier.sv
// Maps a column index to its pixel class: discard, black reference or active.
// Assumes: DUMMY_PIX + BLACK_PIX <= COLS.
module ccd_col_classifier
    import ccd_seq_pkg::*;
#(
    parameter int COLS      = 680,
    parameter int DUMMY_PIX = 4,
    parameter int BLACK_PIX = 22,
    localparam int CW       = $clog2(COLS)
) (
    input  logic          valid,
    input  logic [CW-1:0] col,
    output logic [1:0]    cls
);

    localparam int BLACK_END = DUMMY_PIX + BLACK_PIX;

    // region compare
    always_comb begin
        if (!valid)                      cls = PIX_NONE;
        else if (int'(col) < DUMMY_PIX)  cls = PIX_DUMMY;
        else if (int'(col) < BLACK_END)  cls = PIX_BLACK;
        else                             cls = PIX_ACTIVE;
    end

endmodule

// File: rtl/ccd_capture_seq.sv
// Capture sequencer for a frame-transfer sensor: erase, exposure, fast
// image-to-storage shift, then row step + pixel readout for every row, then
// host hand-off. All gate outputs are decoded from registered state.
// Assumes: one clock, synchronous active-low reset, start_req synchronous.
module ccd_capture_seq
    import ccd_seq_pkg::*;
#(
    parameter int RESET_CYC = 25,
    parameter int IW        = 10,
    parameter int ROWS      = 500,
    parameter int COLS      = 680,
    parameter int DUMMY_PIX = 4,
    parameter int BLACK_PIX = 22,
    localparam int CW       = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [IW-1:0] integ_cycles,
    output logic          drain_reset,
    output logic          image_gate,
    output logic          store_gate,
    output logic          serial_gate,
    output logic          row_go,
    output logic          pix_valid,
    output logic [1:0]    pix_class,
    output logic [CW-1:0] pix_col,
    output logic          busy,
    output logic          host_go
);

    localparam int CNT_MAX = max_of3(RESET_CYC, 2 ** IW, 2 * max_of3(ROWS, COLS, 1));
    localparam int CNTW    = $clog2(CNT_MAX + 1);
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1;

    localparam logic [CNTW-1:0] ERASE_LAST = CNTW'(RESET_CYC - 1);
    localparam logic [CNTW-1:0] SHIFT_LAST = CNTW'(2 * ROWS - 1);
    localparam logic [CNTW-1:0] READ_LAST  = CNTW'(2 * COLS - 1);
    localparam logic [CNTW-1:0] STEP_LAST  = CNTW'(1);
    localparam logic [RW-1:0]   ROW_LAST   = RW'(ROWS - 1);

    seq_state_t      st;
    logic            start_q;
    logic            start_edge;
    logic [IW-1:0]   integ_q;
    logic [CNTW-1:0] cyc;
    logic [RW-1:0]   row;
    logic            phase_end;
    logic            cyc_clr;
    logic            row_clr;
    logic            row_inc;
    logic            in_read_pix;

    // start request edge detector
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_req;
    end
    assign start_edge = start_req & ~start_q;

    // exposure length, latched on an accepted start (0 taken as 1)
    always_ff @(posedge clk) begin
        if (!rst_n)
            integ_q <= IW'(1);
        else if (st == ST_IDLE && start_edge)
            integ_q <= (integ_cycles == '0) ? IW'(1) : integ_cycles;
    end

    // end of the current phase
    always_comb begin
        unique case (st)
            ST_ERASE:  phase_end = (cyc == ERASE_LAST);
            ST_EXPOSE: phase_end = (cyc == CNTW'(integ_q - IW'(1)));
            ST_SHIFT:  phase_end = (cyc == SHIFT_LAST);
            ST_STEP:   phase_end = (cyc == STEP_LAST);
            ST_READ:   phase_end = (cyc == READ_LAST);
            default:   phase_end = 1'b0;
        endcase
    end

    assign cyc_clr = phase_end || (st == ST_IDLE) || (st == ST_HAND);
    assign row_clr = (st == ST_SHIFT);
    assign row_inc = (st == ST_READ) && phase_end;

    ccd_step_counter #(.W(CNTW)) i_cyc_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cyc_clr),
        .inc  (1'b1),
        .q    (cyc)
    );

    ccd_step_counter #(.W(RW)) i_row_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (row_clr),
        .inc  (row_inc),
        .q    (row)
    );

    // phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   if (start_edge) st <= ST_ERASE;
                ST_ERASE:  if (phase_end)  st <= ST_EXPOSE;
                ST_EXPOSE: if (phase_end)  st <= ST_SHIFT;
                ST_SHIFT:  if (phase_end)  st <= ST_STEP;
                ST_STEP:   if (phase_end)  st <= ST_READ;
                ST_READ:   if (phase_end)  st <= (row == ROW_LAST) ? ST_HAND : ST_STEP;
                ST_HAND:                   st <= ST_IDLE;
                default:                   st <= ST_IDLE;
            endcase
        end
    end

    // gate and status decode
    assign in_read_pix = (st == ST_READ) && cyc[0];
    assign drain_reset = (st == ST_ERASE);
    assign image_gate  = (st == ST_SHIFT) && !cyc[0];
    assign store_gate  = ((st == ST_SHIFT) && !cyc[0]) || ((st == ST_STEP) && cyc == '0);
    assign serial_gate = ((st == ST_STEP) && cyc == STEP_LAST) || ((st == ST_READ) && !cyc[0]);
    assign row_go      = (st == ST_READ) && (cyc == '0);
    assign pix_valid   = in_read_pix;
    assign pix_col     = in_read_pix ? cyc[CW:1] : '0;
    assign busy        = (st != ST_IDLE) && (st != ST_HAND);
    assign host_go     = (st == ST_HAND);

    ccd_col_classifier #(
        .COLS     (COLS),
        .DUMMY_PIX(DUMMY_PIX),
        .BLACK_PIX(BLACK_PIX)
    ) i_classifier (
        .valid(pix_valid),
        .col  (pix_col),
        .cls  (pix_class)
    );

    // R1: an accepted start enters the erase phase with busy set
    a_r1_start_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_edge) |=> (drain_reset && busy));

    // R2: the erase pulse can only begin from idle
    a_r2_erase_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_reset) |-> $past(st == ST_IDLE));

    // R4: the image gate never pulses without the storage gate
    a_r4_shift_pair: assert property (@(posedge clk) disable iff (!rst_n)
        image_gate |-> store_gate);

    // R5: a lone storage pulse is followed by the serial load pulse
    a_r5_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (store_gate && !image_gate) |=> (serial_gate && !store_gate));

    // R6: gates never overlap across phases
    a_r6_gate_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_reset, image_gate, serial_gate}));

    // R7: column zero of every row is a discard pixel
    a_r7_first_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_col == '0) |-> (pix_class == PIX_DUMMY));

    // R8: the host go pulse follows a busy cycle and comes with busy low
    a_r8_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_go) |-> (!busy && $past(busy)));

    // R9: no new erase while a capture is running
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(drain_reset));

endmodule

// File: tb/test_ccd_capture_seq.sv
// Scoreboard bench: the driver pushes the expected per-cycle output words for
// a capture into a queue; a monitor pops and compares one word per cycle.
module test_ccd_capture_seq;

    localparam int RESET_CYC = 4;
    localparam int IW        = 4;
    localparam int ROWS      = 3;
    localparam int COLS      = 8;
    localparam int DUMMY_PIX = 2;
    localparam int BLACK_PIX = 2;
    localparam int CW        = $clog2(COLS);
    localparam int EW        = 10 + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic [IW-1:0] integ_cycles = '0;
    logic          drain_reset, image_gate, store_gate, serial_gate;
    logic          row_go, pix_valid, busy, host_go;
    logic [1:0]    pix_class;
    logic [CW-1:0] pix_col;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;
    bit finished = 1'b0;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    ccd_capture_seq #(
        .RESET_CYC(RESET_CYC),
        .IW       (IW),
        .ROWS     (ROWS),
        .COLS     (COLS),
        .DUMMY_PIX(DUMMY_PIX),
        .BLACK_PIX(BLACK_PIX)
    ) i_ccd_capture_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .integ_cycles(integ_cycles),
        .drain_reset (drain_reset),
        .image_gate  (image_gate),
        .store_gate  (store_gate),
        .serial_gate (serial_gate),
        .row_go      (row_go),
        .pix_valid   (pix_valid),
        .pix_class   (pix_class),
        .pix_col     (pix_col),
        .busy        (busy),
        .host_go     (host_go)
    );

    function automatic logic [EW-1:0] word(
        input bit d, input bit ig, input bit sg, input bit se, input bit rg,
        input bit pv, input logic [1:0] cl, input int col, input bit bz, input bit hg);
        return {d, ig, sg, se, rg, pv, cl, CW'(col), bz, hg};
    endfunction

    function automatic logic [EW-1:0] observed();
        return {drain_reset, image_gate, store_gate, serial_gate, row_go,
                pix_valid, pix_class, pix_col, busy, host_go};
    endfunction

    function automatic logic [1:0] class_of(input int col);
        if (col < DUMMY_PIX)             return 2'd1;
        if (col < DUMMY_PIX + BLACK_PIX) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(input string tag, input logic [EW-1:0] got, input logic [EW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    // driver side: expected trace of one capture
    task automatic push_capture(input int integ);
        int n_exp;
        n_exp = (integ == 0) ? 1 : integ;
        for (int i = 0; i < RESET_CYC; i++) begin
            exp_q.push_back(word(1,0,0,0,0,0,2'd0,0,1,0)); tag_q.push_back("R2");
        end
        for (int i = 0; i < n_exp; i++) begin
            exp_q.push_back(word(0,0,0,0,0,0,2'd0,0,1,0)); tag_q.push_back("R3");
        end
        for (int r = 0; r < ROWS; r++) begin
            exp_q.push_back(word(0,1,1,0,0,0,2'd0,0,1,0)); tag_q.push_back("R4");
            exp_q.push_back(word(0,0,0,0,0,0,2'd0,0,1,0)); tag_q.push_back("R4");
        end
        for (int r = 0; r < ROWS; r++) begin
            exp_q.push_back(word(0,0,1,0,0,0,2'd0,0,1,0)); tag_q.push_back("R5");
            exp_q.push_back(word(0,0,0,1,0,0,2'd0,0,1,0)); tag_q.push_back("R5");
            for (int p = 0; p < COLS; p++) begin
                exp_q.push_back(word(0,0,0,1,(p == 0),0,2'd0,0,1,0)); tag_q.push_back("R6");
                exp_q.push_back(word(0,0,0,0,0,1,class_of(p),p,1,0)); tag_q.push_back("R6/R7");
            end
        end
        exp_q.push_back(word(0,0,0,0,0,0,2'd0,0,0,1)); tag_q.push_back("R8");
        exp_q.push_back(word(0,0,0,0,0,0,2'd0,0,0,0)); tag_q.push_back("R8");
    endtask

    // monitor side: one comparison per cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && exp_q.size() > 0) begin
            logic [EW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, observed(), e);
        end
    end

    task automatic run_capture(input logic [IW-1:0] integ, input bit disturb);
        push_capture(int'(integ));
        @(negedge clk);
        integ_cycles = integ;
        start_req = 1'b1;
        @(posedge clk);
        #1 armed = 1'b1;
        if (disturb) begin
            // R9: start edge and new exposure value mid-capture
            repeat (6) @(negedge clk);
            start_req = 1'b0;
            integ_cycles = ~integ;
            repeat (3) @(negedge clk);
            start_req = 1'b1;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        armed = 1'b0;
        start_req = 1'b0;
        @(negedge clk);
        check("R8 idle after hand-off", observed(), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 outputs in reset", observed(), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle after reset", observed(), '0);

        run_capture(4'd3, 1'b1);   // R1 R9 with mid-run disturbance
        run_capture(4'd0, 1'b0);   // R3 zero exposure counts as one
        run_capture(4'd15, 1'b0);  // R3 largest exposure

        // R10: reset in mid-capture returns to idle
        @(negedge clk);
        start_req = 1'b1;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset mid-capture", observed(), '0);
        rst_n = 1'b1;
        start_req = 1'b0;
        @(negedge clk);
        check("R10 still idle", observed(), '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired checks so far=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule